// File: doc/BRIEF.md
# Hourly chime tone generator

This block turns the running time of day into the audible warning that precedes each hour. It watches the minute and second digits, given in BCD, from the timekeeping counter. During the last minute of the hour it drives a one-bit speaker line with four short low beeps and then one high beep. The high beep stops at the moment the clock rolls over to the hour. Outside that window the speaker line stays low.

Both tones come from the block's own system clock. A parameter gives the clock frequency. From it the block derives a 1024 Hz square wave and a 2048 Hz square wave with counters that advance every clock cycle, so no second clock domain is created. A beep lasts for as long as the matching second is shown on the digits. Each tone counter restarts when its beep begins, so every beep opens with the same phase. A master enable input mutes the chime completely.

The digits and the enable pass through an input register. The tone selection is then registered, and so is the speaker output. Decode glitches therefore never reach the pin, and the response has a fixed latency.

Top module: `chime_tone_gen`

## Requirements
- R1: The speaker output is low whenever the minute digits (tens, ones) did not read 5, 9 at the input sample that the output reflects.
- R2: With minutes 59 and seconds 51, 53, 55 or 57 (seconds tens digit 5, ones digit 1, 3, 5 or 7), the speaker carries the low tone. The low tone is a square wave with a half period of SYS_CLK_HZ/(2*1024) clock cycles.
- R3: With minutes 59 and seconds 59, the speaker carries the high tone. The high tone is a square wave with a half period of SYS_CLK_HZ/(2*2048) clock cycles.
- R4: When the digits leave 59:59 for the hour (00:00), the high beep ends and the speaker is low from the third clock edge after the change, counting the sampling edge as the first.
- R5: With minutes 59, every second other than 51, 53, 55, 57 and 59 keeps the speaker low. This includes seconds whose ones digit is odd but whose tens digit is not 5.
- R6: Each tone has 50% duty. The output is high for exactly one half period and then low for exactly one half period, repeating.
- R7: Each beep starts with the output high for a full half period, whatever phase the previous beep ended in. This holds after a silent second and when a low beep is followed directly by the high beep.
- R8: While chime_en is low, the speaker output is low at every time value.
- R9: A new set of digits or a new enable value is sampled on the first rising edge after it is applied. The speaker reflects that sample from the third rising edge on.
- R10: While rst_n is low, the speaker output is low. After reset is released, the output stays low until a chiming time is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at SYS_CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| chime_en | input | 1 | Master chime enable; low mutes the speaker |
| min_tens | input | DIGIT_W | Minute tens digit, BCD |
| min_ones | input | DIGIT_W | Minute ones digit, BCD |
| sec_tens | input | DIGIT_W | Second tens digit, BCD |
| sec_ones | input | DIGIT_W | Second ones digit, BCD |
| speaker_o | output | 1 | Tone output to the speaker driver |

## Verification
The assertions assume that the digit inputs are synchronous to clk and are held at least one cycle. They also assume that chime_en is low while reset is active, because the mute check looks back three cycles and may reach into the reset period. The stimulus changes inputs only just after a falling edge and keeps every value steady for many cycles. It drives chime_en low throughout reset. The bench shortens the tone half periods by lowering SYS_CLK_HZ, which leaves every cycle relation unchanged.

// File: rtl/chime_pkg.sv
package chime_pkg;

    typedef enum logic [1:0] {
        TONE_OFF  = 2'd0,
        TONE_LOW  = 2'd1,
        TONE_HIGH = 2'd2
    } tone_e;

    localparam int NUM_TONES = 2;
    localparam int IDX_LOW   = 0;
    localparam int IDX_HIGH  = 1;

    localparam int CHIME_MIN_TENS = 5;
    localparam int CHIME_MIN_ONES = 9;
    localparam int CHIME_SEC_TENS = 5;

endpackage

// File: rtl/chime_time_decode.sv
module chime_time_decode
    import chime_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chime_en,
    input  logic [DIGIT_W-1:0] min_tens,
    input  logic [DIGIT_W-1:0] min_ones,
    input  logic [DIGIT_W-1:0] sec_tens,
    input  logic [DIGIT_W-1:0] sec_ones,
    output tone_e              sel_q,
    output logic [NUM_TONES-1:0] restart_o
);

    typedef struct packed {
        logic [DIGIT_W-1:0] mt;
        logic [DIGIT_W-1:0] mo;
        logic [DIGIT_W-1:0] st;
        logic [DIGIT_W-1:0] so;
        logic               en;
        tone_e              sel;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       last_minute;
    logic       low_second;
    logic       high_second;

    always_comb begin
        st_d    = st_q;
        st_d.mt = min_tens;
        st_d.mo = min_ones;
        st_d.st = sec_tens;
        st_d.so = sec_ones;
        st_d.en = chime_en;

        last_minute = (st_q.mt == DIGIT_W'(CHIME_MIN_TENS)) &&
                      (st_q.mo == DIGIT_W'(CHIME_MIN_ONES));
        low_second  = (st_q.st == DIGIT_W'(CHIME_SEC_TENS)) &&
                      ((st_q.so == DIGIT_W'(1)) || (st_q.so == DIGIT_W'(3)) ||
                       (st_q.so == DIGIT_W'(5)) || (st_q.so == DIGIT_W'(7)));
        high_second = (st_q.st == DIGIT_W'(CHIME_SEC_TENS)) &&
                      (st_q.so == DIGIT_W'(9));

        if (!st_q.en || !last_minute) begin
            st_d.sel = TONE_OFF;
        end else if (low_second) begin
            st_d.sel = TONE_LOW;
        end else if (high_second) begin
            st_d.sel = TONE_HIGH;
        end else begin
            st_d.sel = TONE_OFF;
        end

        restart_o           = '0;
        restart_o[IDX_LOW]  = (st_d.sel == TONE_LOW)  && (st_q.sel != TONE_LOW);
        restart_o[IDX_HIGH] = (st_d.sel == TONE_HIGH) && (st_q.sel != TONE_HIGH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mt: '0, mo: '0, st: '0, so: '0, en: 1'b0, sel: TONE_OFF};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q = st_q.sel;

    // R8
    mute_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |=> (st_q.sel == TONE_OFF));

    // R5
    off_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st != DIGIT_W'(CHIME_SEC_TENS)) |=> (st_q.sel == TONE_OFF));

    // R7
    restart_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(restart_o));

endmodule

// File: rtl/chime_tone_div.sv
module chime_tone_div #(
    parameter int HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic phase_o
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          phase;
    } div_state_t;

    div_state_t dv_d, dv_q;

    always_comb begin
        dv_d = dv_q;
        if (restart_i) begin
            dv_d.cnt   = '0;
            dv_d.phase = 1'b1;
        end else if (dv_q.cnt == LAST) begin
            dv_d.cnt   = '0;
            dv_d.phase = ~dv_q.phase;
        end else begin
            dv_d.cnt   = dv_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv_q <= '{cnt: '0, phase: 1'b0};
        end else begin
            dv_q <= dv_d;
        end
    end

    assign phase_o = dv_q.phase;

    // R7
    restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (dv_q.phase && (dv_q.cnt == '0)));

    // R6
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && (dv_q.cnt != LAST)) |=> $stable(dv_q.phase));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.cnt <= LAST);

endmodule

// File: rtl/chime_tone_gen.sv
module chime_tone_gen
    import chime_pkg::*;
#(
    parameter int SYS_CLK_HZ = 50_000_000,
    parameter int LOW_HZ     = 1024,
    parameter int HIGH_HZ    = 2048,
    parameter int DIGIT_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chime_en,
    input  logic [DIGIT_W-1:0] min_tens,
    input  logic [DIGIT_W-1:0] min_ones,
    input  logic [DIGIT_W-1:0] sec_tens,
    input  logic [DIGIT_W-1:0] sec_ones,
    output logic               speaker_o
);

    localparam int HALF_LOW_RAW  = SYS_CLK_HZ / (2 * LOW_HZ);
    localparam int HALF_HIGH_RAW = SYS_CLK_HZ / (2 * HIGH_HZ);
    localparam int HALF_LOW      = (HALF_LOW_RAW  < 1) ? 1 : HALF_LOW_RAW;
    localparam int HALF_HIGH     = (HALF_HIGH_RAW < 1) ? 1 : HALF_HIGH_RAW;

    tone_e                sel_q;
    logic [NUM_TONES-1:0] restart;
    logic [NUM_TONES-1:0] tone_phase;
    logic                 spk_d, spk_q;

    chime_time_decode #(
        .DIGIT_W (DIGIT_W)
    ) decode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chime_en  (chime_en),
        .min_tens  (min_tens),
        .min_ones  (min_ones),
        .sec_tens  (sec_tens),
        .sec_ones  (sec_ones),
        .sel_q     (sel_q),
        .restart_o (restart)
    );

    for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
        localparam int HALF_T = (t == IDX_LOW) ? HALF_LOW : HALF_HIGH;
        chime_tone_div #(
            .HALF (HALF_T)
        ) div_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (restart[t]),
            .phase_o   (tone_phase[t])
        );
    end

    always_comb begin
        unique case (sel_q)
            TONE_LOW:  spk_d = tone_phase[IDX_LOW];
            TONE_HIGH: spk_d = tone_phase[IDX_HIGH];
            default:   spk_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spk_q <= 1'b0;
        end else begin
            spk_q <= spk_d;
        end
    end

    assign speaker_o = spk_q;

    // R1
    off_minute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past((min_tens != DIGIT_W'(CHIME_MIN_TENS)) ||
              (min_ones != DIGIT_W'(CHIME_MIN_ONES)), 3) |-> !speaker_o);

    // R8
    muted_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!chime_en, 3) |-> !speaker_o);

    // R5
    tone_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(speaker_o) |-> ($past(sel_q) != TONE_OFF));

endmodule

// File: tb/chime_tone_gen_tb.sv
module chime_tone_gen_tb_top;

    localparam int SYS_HZ  = 32768;
    localparam int HL      = SYS_HZ / (2 * 1024);
    localparam int HH      = SYS_HZ / (2 * 2048);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chime_en = 1'b0;
    logic [3:0] min_tens = '0, min_ones = '0, sec_tens = '0, sec_ones = '0;
    logic       speaker_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    chime_tone_gen #(
        .SYS_CLK_HZ (SYS_HZ),
        .DIGIT_W    (4)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chime_en  (chime_en),
        .min_tens  (min_tens),
        .min_ones  (min_ones),
        .sec_tens  (sec_tens),
        .sec_ones  (sec_ones),
        .speaker_o (speaker_o)
    );

    task automatic check_bit(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: speaker=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Applies a time, waits for the output latency, then compares a window of
    // samples with an ideal square wave (half=0 means silence).
    task automatic beep_case(input int mt, input int mo, input int st, input int so,
                             input logic en, input int half, input int len,
                             input string req);
        int   errs = 0;
        logic first_act = 1'b0;
        logic first_exp = 1'b0;
        int   first_i = -1;
        @(negedge clk);
        min_tens = 4'(mt); min_ones = 4'(mo);
        sec_tens = 4'(st); sec_ones = 4'(so);
        chime_en = en;
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < len; i++) begin
            logic exp;
            if (i > 0) begin
                @(posedge clk);
                #1;
            end
            exp = (half == 0) ? 1'b0 : (((i / half) % 2) == 0);
            if (speaker_o !== exp) begin
                if (errs == 0) begin
                    first_act = speaker_o; first_exp = exp; first_i = i;
                end
                errs++;
            end
        end
        total++;
        if (errs != 0) begin
            bad++;
            $display("FAIL %s: %0d:%0d%0d:%0d%0d sample %0d speaker=%b expected=%b",
                     req, mt, mo, st, so, 0, first_i, first_act, first_exp);
        end
    endtask

    task automatic test_reset();
        // R10
        check_bit(speaker_o, 1'b0, "R10 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check_bit(speaker_o, 1'b0, "R10 after release");
    endtask

    task automatic test_latency();
        // R9: sampled at edge 1, visible from edge 3
        @(negedge clk);
        min_tens = 4'd5; min_ones = 4'd9; sec_tens = 4'd5; sec_ones = 4'd1;
        chime_en = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check_bit(speaker_o, 1'b0, "R9 edge two still quiet");
        @(posedge clk);
        #1;
        check_bit(speaker_o, 1'b1, "R9 edge three sounding");
        beep_case(5, 9, 5, 0, 1'b1, 0, 10, "R5 settle quiet");
    endtask

    task automatic test_low_beeps();
        // R2 R6
        beep_case(5, 9, 5, 1, 1'b1, HL, 4 * HL, "R2 R6 low at 51");
        beep_case(5, 9, 5, 2, 1'b1, 0, 8, "R5 quiet at 52");
        beep_case(5, 9, 5, 3, 1'b1, HL, 3 * HL, "R2 low at 53");
        beep_case(5, 9, 5, 4, 1'b1, 0, 8, "R5 quiet at 54");
        beep_case(5, 9, 5, 5, 1'b1, HL, 3 * HL, "R2 low at 55");
        beep_case(5, 9, 5, 6, 1'b1, 0, 8, "R5 quiet at 56");
        beep_case(5, 9, 5, 7, 1'b1, HL, 3 * HL, "R2 low at 57");
    endtask

    task automatic test_high_and_hour();
        // R3 R7 R4: low beep straight into high beep, then the hour
        beep_case(5, 9, 5, 9, 1'b1, HH, 6 * HH + 3, "R3 R7 high at 59");
        beep_case(0, 0, 0, 0, 1'b1, 0, 40, "R4 quiet on the hour");
    endtask

    task automatic test_quiet_seconds();
        // R5
        beep_case(5, 9, 5, 8, 1'b1, 0, 20, "R5 quiet at 58");
        beep_case(5, 9, 4, 1, 1'b1, 0, 20, "R5 quiet at 41");
        beep_case(5, 9, 0, 9, 1'b1, 0, 20, "R5 quiet at 09");
    endtask

    task automatic test_other_minutes();
        // R1
        beep_case(5, 8, 5, 1, 1'b1, 0, 40, "R1 minute 58");
        beep_case(4, 9, 5, 9, 1'b1, 0, 40, "R1 minute 49");
        beep_case(0, 9, 5, 3, 1'b1, 0, 40, "R1 minute 09");
    endtask

    task automatic test_restart();
        // R7: stop mid-phase, silence, next beep starts high again
        beep_case(5, 9, 5, 1, 1'b1, HL, HL + 5, "R7 partial beep");
        beep_case(5, 9, 5, 2, 1'b1, 0, 3, "R7 gap");
        beep_case(5, 9, 5, 3, 1'b1, HL, 3 * HL, "R7 fresh phase");
        beep_case(5, 9, 5, 9, 1'b1, HH, 4 * HH, "R7 direct low to high");
    endtask

    task automatic test_mute();
        // R8
        beep_case(5, 9, 5, 1, 1'b0, 0, 40, "R8 muted low second");
        beep_case(5, 9, 5, 9, 1'b0, 0, 40, "R8 muted high second");
        beep_case(5, 9, 5, 9, 1'b1, HH, 4 * HH, "R8 unmute sounds");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        test_latency();
        test_low_beeps();
        test_high_and_hour();
        test_quiet_seconds();
        test_other_minutes();
        test_restart();
        test_mute();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule